// File: doc/BRIEF.md
# Key-Protected Pin Multiplexing Controller

This block decides, pad by pad, whether a pin is driven by the general-purpose I/O path or by one of eight peripheral outputs. Software configures it through a plain register write port. Three register banks hold the routing. The routing-select bank has one bit per pin, 0 for GPIO and 1 for peripheral. The function-select bank has a 3-bit index per pin, ten pins per word. The module-select bank is passed straight out to peripheral blocks.

Every write to one of these banks is guarded by a one-shot key. Software first writes the bitwise complement of the intended data to a write-only key register. The next write to a guarded register is accepted only if its data is the exact complement of that key. Each attempt on a guarded register uses up the key, whether it was accepted or not. A pad multiplexer turns the stored routing into the pad drive. To move a pin to a peripheral, the usual order is to set its function index and any module selects first, and then set its routing bit. To return a pin to GPIO, clearing its routing bit is enough.

The register port is a control interface. It has no back-pressure: a write is taken on every edge where `bus_we` is high, and reads are combinational.

Top module: `pinmux_guard`

## Requirements
- R1: After reset, every routing, function and module register reads 0, every pin is GPIO with function index 0, and the key is disarmed.
- R2: A write to word address 0 (the key register) stores the data as the key and arms it. A later key write replaces the earlier key. Reading address 0 always returns 0.
- R3: A write to a guarded address is accepted when the key is armed and the write data equals the bitwise complement of the key. Guarded addresses are 1–7 for routing, 8–21 for function and 22–24 for module select. The accepted data is the register's content from the next edge.
- R4: A write to a guarded address while the key is disarmed leaves every register unchanged.
- R5: A write to a guarded address whose data is not the complement of the armed key leaves every register unchanged.
- R6: Any write to a guarded address disarms the key, accepted or not. The following guarded write is ignored unless a new key write comes first.
- R7: A pin with routing bit 0 drives `pad_out` from `gpio_out[p]`. With routing bit 1 it drives `pad_out` from `periph_out[p*8 + idx]`, where idx is the pin's function index.
- R8: Pin p's routing bit is bit p%32 of routing word p/32. Its function index is bits [(p%10)*3 +: 3] of function word p/10. Both are presented on `pin_periph_en[p]` and `pin_func_idx[p*3 +: 3]`.
- R9: Clearing a pin's routing bit returns it to GPIO and leaves its function index unchanged.
- R10: A read of a register address returns its full 32-bit content. Addresses 25–31 read as 0. Writes to them change nothing, including the key state.
- R11: `mod_sel` presents the three module-select words, with word k at bits [k*32 +: 32].
- R12: Routing and pad selection change only on the edge that accepts a guarded write, and they hold in every cycle without a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, taken on every edge while high |
| bus_waddr | input | 5 | Write word address |
| bus_wdata | input | 32 | Write data |
| bus_raddr | input | 5 | Read word address |
| bus_rdata | output | 32 | Combinational read data |
| gpio_out | input | 140 | GPIO drive value per pin |
| periph_out | input | 1120 | Eight peripheral drive values per pin |
| pad_out | output | 140 | Selected pad drive per pin |
| pin_periph_en | output | 140 | Routing bit per pin |
| pin_func_idx | output | 420 | 3-bit function index per pin |
| mod_sel | output | 96 | Module-select words |

## Verification
A key that stays armed or a comparison that is off shows up on the first guarded write after the key. The bench reads the register back one cycle later and finds a changed word where the old one should be. Corruption in the register banks appears at once on `pin_periph_en`, `pin_func_idx` and `bus_rdata`. A wrong slice in the pad multiplexer shows on `pad_out` in the same cycle for the affected pin, but only when `gpio_out` and that pin's eight peripheral inputs differ. For this reason, the pad sweep uses two input patterns across all 140 pins.

// File: rtl/pmx_pkg.sv
package pmx_pkg;
  localparam int DW = 32;

  typedef enum logic [2:0] {
    RGN_KEY  = 3'd0,
    RGN_GP   = 3'd1,
    RGN_FN   = 3'd2,
    RGN_MOD  = 3'd3,
    RGN_NONE = 3'd4
  } region_e;

  typedef struct packed {
    region_e    rgn;
    logic [7:0] idx;
  } reg_sel_t;

  // Word map: key at 0, then routing, function and module banks back to back.
  function automatic reg_sel_t decode_addr(input int unsigned a, input int unsigned n_gp,
                                           input int unsigned n_fn, input int unsigned n_mod);
    reg_sel_t s;
    s.rgn = RGN_NONE;
    s.idx = '0;
    if (a == 0) begin
      s.rgn = RGN_KEY;
    end else if (a <= n_gp) begin
      s.rgn = RGN_GP;
      s.idx = 8'(a - 1);
    end else if (a <= n_gp + n_fn) begin
      s.rgn = RGN_FN;
      s.idx = 8'(a - 1 - n_gp);
    end else if (a <= n_gp + n_fn + n_mod) begin
      s.rgn = RGN_MOD;
      s.idx = 8'(a - 1 - n_gp - n_fn);
    end
    return s;
  endfunction
endpackage

// File: rtl/pmx_key_gate.sv
module pmx_key_gate
  import pmx_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          is_key,
  input  logic          is_guarded,
  input  logic [DW-1:0] wdata,
  output logic          accept,
  output logic          armed,
  output logic [DW-1:0] key_q
);
  logic key_match;

  assign key_match = (wdata == ~key_q);
  assign accept    = wr_en && is_guarded && armed && key_match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      key_q <= '0;
    end else if (wr_en && is_key) begin
      armed <= 1'b1;
      key_q <= wdata;
    end else if (wr_en && is_guarded) begin
      armed <= 1'b0;
    end
  end
endmodule

// File: rtl/pmx_regfile.sv
module pmx_regfile
  import pmx_pkg::*;
#(
  parameter int N_GP  = 7,
  parameter int N_FN  = 14,
  parameter int N_MOD = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_accept,
  input  reg_sel_t          wsel,
  input  logic [DW-1:0]     wdata,
  output logic [N_GP*DW-1:0]  gp_flat,
  output logic [N_FN*DW-1:0]  fn_flat,
  output logic [N_MOD*DW-1:0] mod_flat
);
  for (genvar i = 0; i < N_GP; i++) begin : g_gp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gp_flat[i*DW +: DW] <= '0;
      else if (wr_accept && wsel.rgn == RGN_GP && wsel.idx == 8'(i))
        gp_flat[i*DW +: DW] <= wdata;
    end
  end

  for (genvar i = 0; i < N_FN; i++) begin : g_fn
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fn_flat[i*DW +: DW] <= '0;
      else if (wr_accept && wsel.rgn == RGN_FN && wsel.idx == 8'(i))
        fn_flat[i*DW +: DW] <= wdata;
    end
  end

  for (genvar i = 0; i < N_MOD; i++) begin : g_mod
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mod_flat[i*DW +: DW] <= '0;
      else if (wr_accept && wsel.rgn == RGN_MOD && wsel.idx == 8'(i))
        mod_flat[i*DW +: DW] <= wdata;
    end
  end
endmodule

// File: rtl/pmx_pad_mux.sv
module pmx_pad_mux #(
  parameter int NUM_PINS = 140,
  parameter int FN_W     = 3,
  localparam int NF      = 1 << FN_W
) (
  input  logic [NUM_PINS-1:0]      periph_en,
  input  logic [NUM_PINS*FN_W-1:0] func_idx,
  input  logic [NUM_PINS-1:0]      gpio_out,
  input  logic [NUM_PINS*NF-1:0]   periph_out,
  output logic [NUM_PINS-1:0]      pad_out
);
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic [NF-1:0]   choices;
    logic [FN_W-1:0] idx;
    assign choices    = periph_out[p*NF +: NF];
    assign idx        = func_idx[p*FN_W +: FN_W];
    assign pad_out[p] = periph_en[p] ? choices[idx] : gpio_out[p];
  end
endmodule

// File: rtl/pinmux_guard.sv
module pinmux_guard
  import pmx_pkg::*;
#(
  parameter int N_GP   = 7,
  parameter int N_FN   = 14,
  parameter int N_MOD  = 3,
  parameter int FN_W   = 3,
  parameter int ADDR_W = 5,
  localparam int FN_PER_REG = DW / FN_W,
  localparam int NUM_PINS   = N_FN * FN_PER_REG,
  localparam int NUM_FUNCS  = 1 << FN_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_we,
  input  logic [ADDR_W-1:0]           bus_waddr,
  input  logic [DW-1:0]               bus_wdata,
  input  logic [ADDR_W-1:0]           bus_raddr,
  output logic [DW-1:0]               bus_rdata,
  input  logic [NUM_PINS-1:0]         gpio_out,
  input  logic [NUM_PINS*NUM_FUNCS-1:0] periph_out,
  output logic [NUM_PINS-1:0]         pad_out,
  output logic [NUM_PINS-1:0]         pin_periph_en,
  output logic [NUM_PINS*FN_W-1:0]    pin_func_idx,
  output logic [N_MOD*DW-1:0]         mod_sel
);
  reg_sel_t wsel, rsel;
  logic     accept, key_armed;
  logic [DW-1:0] key_q;
  logic [N_GP*DW-1:0]  gp_flat;
  logic [N_FN*DW-1:0]  fn_flat;
  logic [N_MOD*DW-1:0] mod_flat;
  logic is_key, is_guarded;

  assign wsel = decode_addr(int'(bus_waddr), N_GP, N_FN, N_MOD);
  assign rsel = decode_addr(int'(bus_raddr), N_GP, N_FN, N_MOD);
  assign is_key     = (wsel.rgn == RGN_KEY);
  assign is_guarded = (wsel.rgn == RGN_GP) || (wsel.rgn == RGN_FN) || (wsel.rgn == RGN_MOD);

  pmx_key_gate u_key (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (bus_we),
    .is_key     (is_key),
    .is_guarded (is_guarded),
    .wdata      (bus_wdata),
    .accept     (accept),
    .armed      (key_armed),
    .key_q      (key_q)
  );

  pmx_regfile #(.N_GP(N_GP), .N_FN(N_FN), .N_MOD(N_MOD)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_accept (accept),
    .wsel      (wsel),
    .wdata     (bus_wdata),
    .gp_flat   (gp_flat),
    .fn_flat   (fn_flat),
    .mod_flat  (mod_flat)
  );

  // Per-pin view of the banks: one routing bit per pin, FN_PER_REG indices per word.
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_map
    assign pin_periph_en[p] = gp_flat[(p / DW) * DW + (p % DW)];
    assign pin_func_idx[p*FN_W +: FN_W] =
      fn_flat[(p / FN_PER_REG) * DW + (p % FN_PER_REG) * FN_W +: FN_W];
  end

  assign mod_sel = mod_flat;

  pmx_pad_mux #(.NUM_PINS(NUM_PINS), .FN_W(FN_W)) u_pad (
    .periph_en  (pin_periph_en),
    .func_idx   (pin_func_idx),
    .gpio_out   (gpio_out),
    .periph_out (periph_out),
    .pad_out    (pad_out)
  );

  always_comb begin
    unique case (rsel.rgn)
      RGN_GP:  bus_rdata = gp_flat[int'(rsel.idx)*DW +: DW];
      RGN_FN:  bus_rdata = fn_flat[int'(rsel.idx)*DW +: DW];
      RGN_MOD: bus_rdata = mod_flat[int'(rsel.idx)*DW +: DW];
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pmx_chk.sv
module pmx_chk #(
  parameter int N_GP   = 7,
  parameter int N_FN   = 14,
  parameter int N_MOD  = 3,
  parameter int ADDR_W = 5,
  parameter int NPIN   = 140,
  parameter int NIDX   = 420
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_we,
  input logic [ADDR_W-1:0]    bus_waddr,
  input logic [31:0]          bus_wdata,
  input logic [ADDR_W-1:0]    bus_raddr,
  input logic [31:0]          bus_rdata,
  input logic                 key_armed,
  input logic [31:0]          key_q,
  input logic [N_GP*32-1:0]   gp_flat,
  input logic [N_FN*32-1:0]   fn_flat,
  input logic [N_MOD*32-1:0]  mod_flat,
  input logic [NPIN-1:0]      pin_periph_en,
  input logic [NIDX-1:0]      pin_func_idx
);
  logic guarded_wr;
  assign guarded_wr = bus_we && (int'(bus_waddr) >= 1) &&
                      (int'(bus_waddr) <= N_GP + N_FN + N_MOD);

  // R2
  key_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_raddr == '0) |-> (bus_rdata == '0));

  // R2
  key_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_waddr == '0) |=> (key_armed && key_q == $past(bus_wdata)));

  // R4
  unkeyed_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (guarded_wr && !key_armed) |=> ($stable(gp_flat) && $stable(fn_flat) && $stable(mod_flat)));

  // R5
  wrong_key_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (guarded_wr && bus_wdata != ~key_q) |=> ($stable(gp_flat) && $stable(fn_flat) && $stable(mod_flat)));

  // R6
  key_consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    guarded_wr |=> !key_armed);

  // R12
  routing_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> ($stable(pin_periph_en) && $stable(pin_func_idx)));
endmodule

bind pinmux_guard pmx_chk #(
  .N_GP(N_GP), .N_FN(N_FN), .N_MOD(N_MOD), .ADDR_W(ADDR_W),
  .NPIN(NUM_PINS), .NIDX(NUM_PINS*FN_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_waddr(bus_waddr),
  .bus_wdata(bus_wdata), .bus_raddr(bus_raddr), .bus_rdata(bus_rdata),
  .key_armed(key_armed), .key_q(key_q), .gp_flat(gp_flat), .fn_flat(fn_flat),
  .mod_flat(mod_flat), .pin_periph_en(pin_periph_en), .pin_func_idx(pin_func_idx)
);

// File: tb/sim_pinmux_guard.sv
`timescale 1ns/1ps
module sim_pinmux_guard;
  localparam int NGP = 7, NFN = 14, NMOD = 3, NPIN = 140, NF = 8;
  localparam int A_GP = 1, A_FN = 8, A_MOD = 22;

  logic clk = 0, rst_n = 0;
  logic bus_we = 0;
  logic [4:0] bus_waddr = '0, bus_raddr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NPIN-1:0] gpio_out = '0, pad_out, pin_periph_en;
  logic [NPIN*NF-1:0] periph_out = '0;
  logic [NPIN*3-1:0] pin_func_idx;
  logic [NMOD*32-1:0] mod_sel;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] m_gp [NGP];
  logic [31:0] m_fn [NFN];
  logic [31:0] m_mod [NMOD];

  always #2.5 clk = ~clk;

  pinmux_guard u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_waddr(bus_waddr),
    .bus_wdata(bus_wdata), .bus_raddr(bus_raddr), .bus_rdata(bus_rdata),
    .gpio_out(gpio_out), .periph_out(periph_out), .pad_out(pad_out),
    .pin_periph_en(pin_periph_en), .pin_func_idx(pin_func_idx), .mod_sel(mod_sel)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bw(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1; bus_waddr = 5'(a); bus_wdata = d;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic kw(input int a, input logic [31:0] d);
    bw(0, ~d);
    bw(a, d);
  endtask

  task automatic rd_chk(input int a, input logic [31:0] exp, input string req);
    bus_raddr = 5'(a);
    #1;
    chk(bus_rdata === exp, req, bus_rdata, exp);
  endtask

  task automatic check_banks(input string req);
    for (int i = 0; i < NGP; i++) rd_chk(A_GP + i, m_gp[i], req);
    for (int i = 0; i < NFN; i++) rd_chk(A_FN + i, m_fn[i], req);
    for (int i = 0; i < NMOD; i++) rd_chk(A_MOD + i, m_mod[i], req);
  endtask

  // Pin view and pad drive against the bench model, for one input pattern.
  task automatic check_pins(input int seed, input string req);
    for (int j = 0; j < NPIN*NF; j++) periph_out[j] = (((j * 7 + seed) % 3) == 0);
    for (int p = 0; p < NPIN; p++) gpio_out[p] = (((p + seed) % 2) == 1);
    #1;
    for (int p = 0; p < NPIN; p++) begin
      logic en;
      logic [2:0] idx;
      logic expv;
      en  = m_gp[p / 32][p % 32];
      idx = 3'((m_fn[p / 10] >> ((p % 10) * 3)) & 32'h7);
      expv = en ? periph_out[p*NF + int'(idx)] : gpio_out[p];
      chk(pin_periph_en[p] === en, {req, " R8 routing bit"}, 32'(pin_periph_en[p]), 32'(en));
      chk(pin_func_idx[p*3 +: 3] === idx, {req, " R8 function index"}, 32'(pin_func_idx[p*3 +: 3]), 32'(idx));
      chk(pad_out[p] === expv, {req, " R7 pad drive"}, 32'(pad_out[p]), 32'(expv));
    end
  endtask

  function automatic logic [31:0] pat(input int i, input logic [31:0] k);
    return (32'(i + 3) * 32'h2545_F491) ^ k ^ (32'(i) << 7);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NGP; i++) m_gp[i] = '0;
    for (int i = 0; i < NFN; i++) m_fn[i] = '0;
    for (int i = 0; i < NMOD; i++) m_mod[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset state
    check_banks("R1 reset");
    check_pins(1, "R1 reset");
    bw(A_GP, 32'hFFFF_FFFF);  // no key since reset
    rd_chk(A_GP, 32'h0, "R1 key disarmed at reset");

    // R2: key register reads zero after a write
    bw(0, 32'h1234_5678);
    rd_chk(0, 32'h0, "R2 key reads zero");

    // R3 R11: function and module words first, each with its own key
    for (int i = 0; i < NFN; i++) begin m_fn[i] = pat(i, 32'hA5A5_0F0F); kw(A_FN + i, m_fn[i]); end
    for (int i = 0; i < NMOD; i++) begin m_mod[i] = pat(i + 40, 32'h0F1E_2D3C); kw(A_MOD + i, m_mod[i]); end
    check_banks("R3 function/module writes");
    for (int k = 0; k < NMOD; k++)
      chk(mod_sel[k*32 +: 32] === m_mod[k], "R11 module select out", mod_sel[k*32 +: 32], m_mod[k]);
    check_pins(2, "R3 still GPIO");

    // R12: routing changes on the accepting edge, not before
    bw(0, ~32'h0000_0001);
    @(negedge clk);
    bus_we = 1; bus_waddr = 5'(A_GP); bus_wdata = 32'h0000_0001;
    #1;
    chk(pin_periph_en[0] === 1'b0, "R12 before edge", 32'(pin_periph_en[0]), 32'h0);
    @(negedge clk);
    bus_we = 0;
    m_gp[0] = 32'h0000_0001;
    chk(pin_periph_en[0] === 1'b1, "R12 after edge", 32'(pin_periph_en[0]), 32'h1);

    // R3 R7 R8: routing words, then sweep all pins under two patterns
    for (int i = 0; i < NGP; i++) begin m_gp[i] = pat(i + 90, 32'h3C3C_C3C3); kw(A_GP + i, m_gp[i]); end
    check_banks("R3 routing writes");
    check_pins(0, "R7 sweep A");
    check_pins(5, "R7 sweep B");

    // R4 R6: key was used up by the last guarded write
    bw(A_GP, 32'hDEAD_BEEF);
    rd_chk(A_GP, m_gp[0], "R4 unkeyed write ignored");
    bw(A_FN + 3, 32'h0);
    rd_chk(A_FN + 3, m_fn[3], "R4 unkeyed function write ignored");

    // R5: wrong key
    bw(0, 32'h0000_FFFF);
    bw(A_GP + 1, 32'h0000_FFFF);
    rd_chk(A_GP + 1, m_gp[1], "R5 wrong key ignored");

    // R6: a failed attempt also consumes the key
    bw(0, ~32'h5555_AAAA);
    bw(A_GP + 2, 32'h1111_1111);
    bw(A_GP + 2, 32'h5555_AAAA);
    rd_chk(A_GP + 2, m_gp[2], "R6 key consumed by failed try");

    // R2: a second key write replaces the first
    bw(0, ~32'h0BAD_0BAD);
    bw(0, ~32'h7777_0000);
    bw(A_MOD, 32'h0BAD_0BAD);
    rd_chk(A_MOD, m_mod[0], "R2 old key no longer valid");
    bw(0, ~32'h0BAD_0BAD);
    bw(0, ~32'h7777_0000);
    bw(A_MOD, 32'h7777_0000);
    m_mod[0] = 32'h7777_0000;
    rd_chk(A_MOD, m_mod[0], "R2 newest key valid");

    // R10: unmapped writes do nothing, key stays armed, unmapped reads zero
    bw(0, ~32'hC0DE_0001);
    bw(30, 32'hC0DE_0001);
    rd_chk(30, 32'h0, "R10 unmapped reads zero");
    bw(A_GP + 3, 32'hC0DE_0001);
    m_gp[3] = 32'hC0DE_0001;
    rd_chk(A_GP + 3, m_gp[3], "R10 key kept across unmapped write");

    // R9: back to GPIO, function indices untouched
    for (int i = 0; i < NGP; i++) begin m_gp[i] = '0; kw(A_GP + i, 32'h0); end
    check_banks("R9 cleared routing");
    check_pins(3, "R9 back to GPIO");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule